// File: doc/BRIEF.md
# Colour Palette Loader and Indexed Pixel Lookup

This block holds the colour lookup table of a display pipeline. A palette arrives as one burst of 32-bit words. Each word carries two 16-bit entries, and each entry holds a 12-bit RGB444 colour in its low bits. The upper four bits of the very first entry do not belong to the colour. They carry a pixel-depth code. The block captures that code and compares it with the depth mode chosen when the load was started. The depth mode also sets how many bytes the palette occupies, and the burst length follows from that: the byte count divided by four, plus one extra word. The block raises a one-cycle completion pulse when it accepts the final word.

In normal operation the block translates 8-bit pixel indices into 12-bit colours, one index per cycle with one cycle of latency. It does this only when the configured depth is 8 bits per pixel. The table is split into an even bank and an odd bank so that both entries of a word are written in the same cycle. Lookups may continue while a new palette is loading.

Top module: `pal_lut`

## Requirements
- R1: After reset, `busy`, `load_done`, `hdr_err` and `rgb_valid` are 0, `depth_code` is 0, and the configured mode is 1 bpp, so no lookups are served.
- R2: A cycle with `load_start` high latches `mode_sel`, clears the word count and `hdr_err`, and makes `busy` 1 on the next cycle. This also restarts a load already in progress. A word offered in the same cycle as `load_start` is dropped.
- R3: `mode_sel` encodes depth as 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp, and 4 to 7 = 12/16 bpp. The palette size is 256 bytes for codes 0 to 2, 512 bytes for code 3, and 32 bytes otherwise. The burst is bytes/4 + 1 words (65, 129 or 9). Accepting the last word drops `busy` and pulses `load_done` high for exactly one cycle.
- R4: Word w stores its low halfword at entry 2w and its high halfword at entry 2w+1. Only halfword bits 11:0 are kept: red in 11:8, green in 7:4 and blue in 3:0. Bits 15:12 of every other halfword are ignored.
- R5: Bits 15:12 of the first word appear on `depth_code` from the cycle after that word is accepted. Entry 0 still stores bits 11:0 of that halfword as its colour.
- R6: If the captured code differs from the expected value (the `mode_sel` value for 0 to 4, and 4 for 5 to 7), `hdr_err` rises and stays high until the next `load_start`. All entries are still written.
- R7: Only bytes/2 entries are written (256, 128 or 16). Halfwords at higher entry numbers are accepted and discarded, and the earlier contents of those entries survive.
- R8: Words offered while `busy` is 0 change no entry, no status and no output.
- R9: With the configured mode at 8 bpp, `pix_valid` with `pix_index` = i gives `rgb_valid` = 1 and `rgb_out` = entry i on the next cycle. In any other mode `rgb_valid` stays 0.
- R10: If a lookup of entry i falls in the same cycle as the write of entry i, the lookup returns the colour held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_start | input | 1 | Begin (or restart) a palette burst |
| mode_sel | input | 3 | Pixel depth mode latched at load start |
| wr_valid | input | 1 | Palette word valid |
| wr_data | input | 32 | Palette word, two entries |
| pix_valid | input | 1 | Index valid |
| pix_index | input | 8 | Indexed pixel value |
| busy | output | 1 | Burst in progress |
| load_done | output | 1 | One-cycle pulse at burst end |
| hdr_err | output | 1 | Depth code mismatch flag |
| depth_code | output | 4 | Depth code captured from the first entry |
| rgb_valid | output | 1 | Colour output valid |
| rgb_out | output | 12 | RGB444 colour |

## Verification
A palette write and a colour lookup can occur in the same cycle, because lookups are not blocked while a burst is loading. The bench provokes this collision by reloading a fully known 8 bpp palette with new colours. While word 10 is being accepted, it also requests index 20, which is the entry that word writes. The result is judged against the colour from the previous palette, and a later lookup confirms the new colour. A second overlap is covered as well: a restart that coincides with an offered word. There the burst length seen afterwards shows that the word was not counted.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int unsigned MODE_W    = 3;
    localparam int unsigned CODE_W    = 4;
    localparam logic [MODE_W-1:0] MODE_8BPP = 3'd3;

    // Palette footprint in bytes for each depth mode.
    function automatic int unsigned pal_bytes(input logic [MODE_W-1:0] m);
        case (m)
            3'd0, 3'd1, 3'd2: pal_bytes = 256;
            3'd3:             pal_bytes = 512;
            default:          pal_bytes = 32;
        endcase
    endfunction

    // Depth code expected in the header field for a mode.
    function automatic logic [CODE_W-1:0] pal_code(input logic [MODE_W-1:0] m);
        if (m <= 3'd4)
            pal_code = {1'b0, m};
        else
            pal_code = 4'd4;
    endfunction

endpackage

// File: rtl/pal_store.sv
// Two-bank colour storage: even entries in bank 0, odd entries in bank 1.
module pal_store #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned COL_W = 12
) (
    input  logic                        clk,
    input  logic [1:0]                  wr_en,
    input  logic [IDX_W-2:0]            wr_row,
    input  logic [1:0][COL_W-1:0]       wr_col,
    input  logic [IDX_W-2:0]            rd_row,
    output logic [1:0][COL_W-1:0]       rd_col
);
    localparam int unsigned ROWS = 1 << (IDX_W - 1);

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [COL_W-1:0] mem [ROWS];
        logic [COL_W-1:0] rd_q;

        // Registered read returns the content before a same-edge write.
        always_ff @(posedge clk) begin
            if (wr_en[b])
                mem[wr_row] <= wr_col[b];
            rd_q <= mem[rd_row];
        end

        assign rd_col[b] = rd_q;
    end

endmodule

// File: rtl/pal_loader.sv
// Burst sequencer: counts words, unpacks entries, checks the depth header.
module pal_loader
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned COL_W = 12,
    parameter int unsigned ENT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_start,
    input  logic [MODE_W-1:0]           mode_sel,
    input  logic                        wr_valid,
    input  logic [2*ENT_W-1:0]          wr_data,
    output logic                        busy,
    output logic                        load_done,
    output logic                        hdr_err,
    output logic [CODE_W-1:0]           depth_code,
    output logic [MODE_W-1:0]           cfg_mode,
    output logic [1:0]                  wr_en,
    output logic [IDX_W-2:0]            wr_row,
    output logic [1:0][COL_W-1:0]       wr_col
);
    localparam int unsigned CNT_W = IDX_W;

    typedef struct packed {
        logic                busy;
        logic [MODE_W-1:0]   mode;
        logic [CNT_W-1:0]    wcnt;
        logic [CODE_W-1:0]   code;
        logic                err;
        logic                done;
    } ld_state_t;

    ld_state_t st_d, st_q;
    logic        accept;
    logic [31:0] cnt32;
    logic [31:0] words_tot;
    logic [31:0] ents_tot;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        cnt32     = 32'(st_q.wcnt);
        words_tot = pal_bytes(st_q.mode) / 32'd4 + 32'd1;
        ents_tot  = pal_bytes(st_q.mode) / 32'd2;
        accept    = st_q.busy && wr_valid && !load_start;

        wr_en[0]  = accept && ((32'd2 * cnt32) < ents_tot);
        wr_en[1]  = accept && ((32'd2 * cnt32 + 32'd1) < ents_tot);
        wr_row    = st_q.wcnt[IDX_W-2:0];
        wr_col[0] = wr_data[COL_W-1:0];
        wr_col[1] = wr_data[ENT_W+COL_W-1:ENT_W];

        if (load_start) begin
            st_d.busy = 1'b1;
            st_d.mode = mode_sel;
            st_d.wcnt = '0;
            st_d.code = '0;
            st_d.err  = 1'b0;
        end else if (accept) begin
            st_d.wcnt = st_q.wcnt + 1'b1;
            if (cnt32 == 32'd0) begin
                st_d.code = wr_data[ENT_W-1:COL_W];
                st_d.err  = (wr_data[ENT_W-1:COL_W] != pal_code(st_q.mode));
            end
            if (cnt32 + 32'd1 == words_tot) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign busy       = st_q.busy;
    assign load_done  = st_q.done;
    assign hdr_err    = st_q.err;
    assign depth_code = st_q.code;
    assign cfg_mode   = st_q.mode;

endmodule

// File: rtl/pal_lookup.sv
// Index-to-colour stage, active only for 8 bpp indexed mode.
module pal_lookup
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned COL_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pix_valid,
    input  logic [IDX_W-1:0]            pix_index,
    input  logic [MODE_W-1:0]           cfg_mode,
    input  logic [1:0][COL_W-1:0]       rd_col,
    output logic [IDX_W-2:0]            rd_row,
    output logic                        rgb_valid,
    output logic [COL_W-1:0]            rgb_out
);
    typedef struct packed {
        logic valid;
        logic bank;
    } lk_state_t;

    lk_state_t lk_d, lk_q;

    always_comb begin
        lk_d       = lk_q;
        lk_d.valid = pix_valid && (cfg_mode == MODE_8BPP);
        lk_d.bank  = pix_index[0];
        rd_row     = pix_index[IDX_W-1:1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            lk_q <= '0;
        else
            lk_q <= lk_d;
    end

    assign rgb_valid = lk_q.valid;
    assign rgb_out   = lk_q.bank ? rd_col[1] : rd_col[0];

endmodule

// File: rtl/pal_lut.sv
module pal_lut
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned COL_W = 12,
    parameter int unsigned ENT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_start,
    input  logic [2:0]           mode_sel,
    input  logic                 wr_valid,
    input  logic [2*ENT_W-1:0]   wr_data,
    input  logic                 pix_valid,
    input  logic [IDX_W-1:0]     pix_index,
    output logic                 busy,
    output logic                 load_done,
    output logic                 hdr_err,
    output logic [3:0]           depth_code,
    output logic                 rgb_valid,
    output logic [COL_W-1:0]     rgb_out
);
    logic [MODE_W-1:0]       cfg_mode_w;
    logic [1:0]              wr_en_w;
    logic [IDX_W-2:0]        wr_row_w;
    logic [1:0][COL_W-1:0]   wr_col_w;
    logic [IDX_W-2:0]        rd_row_w;
    logic [1:0][COL_W-1:0]   rd_col_w;

    pal_loader #(.IDX_W(IDX_W), .COL_W(COL_W), .ENT_W(ENT_W)) u_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_start (load_start),
        .mode_sel   (mode_sel),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .busy       (busy),
        .load_done  (load_done),
        .hdr_err    (hdr_err),
        .depth_code (depth_code),
        .cfg_mode   (cfg_mode_w),
        .wr_en      (wr_en_w),
        .wr_row     (wr_row_w),
        .wr_col     (wr_col_w)
    );

    pal_store #(.IDX_W(IDX_W), .COL_W(COL_W)) u_store (
        .clk    (clk),
        .wr_en  (wr_en_w),
        .wr_row (wr_row_w),
        .wr_col (wr_col_w),
        .rd_row (rd_row_w),
        .rd_col (rd_col_w)
    );

    pal_lookup #(.IDX_W(IDX_W), .COL_W(COL_W)) u_look (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .pix_index (pix_index),
        .cfg_mode  (cfg_mode_w),
        .rd_col    (rd_col_w),
        .rd_row    (rd_row_w),
        .rgb_valid (rgb_valid),
        .rgb_out   (rgb_out)
    );

endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       load_start,
    input logic       pix_valid,
    input logic       busy,
    input logic       load_done,
    input logic       hdr_err,
    input logic       rgb_valid,
    input logic [1:0] wr_en
);
    // R3: completion is a single-cycle pulse, coinciding with idle
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done);
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (!busy && $past(busy)));

    // R2: start arms the burst; a word offered with start writes nothing
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_start |=> busy);
    assert_start_nowrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_start |-> (wr_en == 2'b00));

    // R6: start clears the header error flag
    assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_start |=> !hdr_err);

    // R8: the table is written only during a burst
    assert_idle_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en != 2'b00) |-> busy);

    // R9: a colour appears only one cycle after a requested index
    assert_rgb_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rgb_valid |-> $past(pix_valid));

endmodule

bind pal_lut pal_lut_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_start (load_start),
    .pix_valid  (pix_valid),
    .busy       (busy),
    .load_done  (load_done),
    .hdr_err    (hdr_err),
    .rgb_valid  (rgb_valid),
    .wr_en      (wr_en_w)
);

// File: tb/pal_lut_test.sv
module pal_lut_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_start = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_index = '0;
    logic        busy, load_done, hdr_err, rgb_valid;
    logic [3:0]  depth_code;
    logic [11:0] rgb_out;

    int checks = 0;
    int errors = 0;
    logic [11:0] exp_mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_lut uut (
        .clk(clk), .rst_n(rst_n), .load_start(load_start), .mode_sel(mode_sel),
        .wr_valid(wr_valid), .wr_data(wr_data), .pix_valid(pix_valid),
        .pix_index(pix_index), .busy(busy), .load_done(load_done),
        .hdr_err(hdr_err), .depth_code(depth_code), .rgb_valid(rgb_valid),
        .rgb_out(rgb_out)
    );

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [11:0] col(input int gen, input int i);
        return 12'((i * 37) + (gen * 291) + 5);
    endfunction

    function automatic int words_for(input logic [2:0] m);
        int bytes;
        bytes = (m == 3'd3) ? 512 : (m <= 3'd2) ? 256 : 32;
        return bytes / 4 + 1;
    endfunction

    function automatic int ents_for(input logic [2:0] m);
        int bytes;
        bytes = (m == 3'd3) ? 512 : (m <= 3'd2) ? 256 : 32;
        return bytes / 2;
    endfunction

    task automatic start_load(input logic [2:0] m, input logic with_word);
        load_start = 1'b1;
        mode_sel   = m;
        wr_valid   = with_word;
        wr_data    = 32'hFFFF_FFFF;
        @(negedge clk);
        load_start = 1'b0;
        wr_valid   = 1'b0;
    endtask

    task automatic push(input logic [31:0] d);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    function automatic logic [31:0] mk_word(input int gen, input int w, input logic [3:0] code);
        logic [3:0] top;
        top = (w == 0) ? code : 4'h9;
        return {4'hA, col(gen, 2*w+1), top, col(gen, 2*w)};
    endfunction

    task automatic lookup(input int idx, input logic exp_v, input string tag);
        pix_valid = 1'b1;
        pix_index = 8'(idx);
        @(negedge clk);
        pix_valid = 1'b0;
        check(rgb_valid == exp_v, {tag, " valid"}, int'(rgb_valid), int'(exp_v));
        if (exp_v)
            check(rgb_out == exp_mem[idx], {tag, " colour"}, int'(rgb_out), int'(exp_mem[idx]));
    endtask

    // Full burst; coll_w >= 0 requests entry 2*coll_w in the cycle that word is written.
    task automatic do_load(input logic [2:0] m, input int gen, input logic [3:0] code,
                           input int coll_w);
        int nw, ne;
        logic [3:0] ecode;
        nw = words_for(m);
        ne = ents_for(m);
        ecode = (m <= 3'd4) ? {1'b0, m} : 4'd4;
        start_load(m, 1'b0);
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        for (int w = 0; w < nw; w++) begin
            if (w == nw - 1)
                check(busy && !load_done, "R3 busy before last word", int'(busy), 1);
            if (w == coll_w) begin
                pix_valid = 1'b1;
                pix_index = 8'(2*w);
            end
            push(mk_word(gen, w, code));
            if (w == coll_w) begin
                pix_valid = 1'b0;
                check(rgb_valid && rgb_out == exp_mem[2*w], "R10 same-cycle lookup",
                      int'(rgb_out), int'(exp_mem[2*w]));
            end
            if (w == 0) begin
                check(depth_code == code, "R5 depth code", int'(depth_code), int'(code));
                check(hdr_err == (code != ecode), "R6 header check", int'(hdr_err),
                      int'(code != ecode));
            end
            if (2*w < ne)   exp_mem[2*w]   = col(gen, 2*w);
            if (2*w+1 < ne) exp_mem[2*w+1] = col(gen, 2*w+1);
        end
        check(load_done && !busy, "R3 done pulse at end", int'(load_done), 1);
        @(negedge clk);
        check(!load_done, "R3 done one cycle", int'(load_done), 0);
        check(hdr_err == (code != ecode), "R6 flag held", int'(hdr_err), int'(code != ecode));
    endtask

    task automatic t_reset();
        check(!busy && !load_done && !hdr_err && !rgb_valid && depth_code == 4'd0,
              "R1 reset state", int'({busy, load_done, hdr_err, rgb_valid, depth_code}), 0);
        lookup(3, 1'b0, "R1 no lookup after reset");
    endtask

    task automatic t_load8();
        do_load(3'd3, 1, 4'h3, -1);
        for (int i = 0; i < 256; i++) lookup(i, 1'b1, "R4 R9 8bpp lookup");
    endtask

    task automatic t_idle_words();
        for (int w = 0; w < 4; w++) begin
            push(32'h5A5A_A5A5 + 32'(w));
            check(!busy && !load_done, "R8 idle word no status", int'({busy, load_done}), 0);
        end
        for (int i = 0; i < 8; i++) lookup(i, 1'b1, "R8 idle word ignored");
    endtask

    task automatic t_short_modes();
        do_load(3'd4, 2, 4'h4, -1);
        lookup(4, 1'b0, "R9 no lookup in 16bpp");
        start_load(3'd3, 1'b0);
        push(mk_word(3, 0, 4'h3));
        exp_mem[0] = col(3, 0);
        exp_mem[1] = col(3, 1);
        for (int i = 0; i < 18; i++) lookup(i, 1'b1, "R7 16bpp entry limit");
        do_load(3'd1, 4, 4'h1, -1);
        start_load(3'd3, 1'b0);
        push(mk_word(5, 0, 4'h3));
        exp_mem[0] = col(5, 0);
        exp_mem[1] = col(5, 1);
        for (int i = 120; i < 132; i++) lookup(i, 1'b1, "R7 2bpp entry limit");
    endtask

    task automatic t_mismatch();
        do_load(3'd3, 6, 4'h2, -1);
        lookup(7, 1'b1, "R6 entries written despite mismatch");
        lookup(0, 1'b1, "R5 entry 0 colour");
        start_load(3'd3, 1'b0);
        check(!hdr_err, "R6 cleared by start", int'(hdr_err), 0);
        check(depth_code == 4'd0, "R2 code cleared by start", int'(depth_code), 0);
    endtask

    task automatic t_restart();
        start_load(3'd3, 1'b0);
        for (int w = 0; w < 3; w++) begin
            push(mk_word(7, w, 4'h3));
            exp_mem[2*w]   = col(7, 2*w);
            exp_mem[2*w+1] = col(7, 2*w+1);
        end
        do_load_with_word();
    endtask

    // Restart while busy, offering a word in the start cycle (it must be dropped).
    task automatic do_load_with_word();
        start_load(3'd3, 1'b1);
        for (int w = 0; w < 129; w++) begin
            if (w == 128)
                check(busy && !load_done, "R2 start word dropped", int'(busy), 1);
            push(mk_word(8, w, 4'h3));
            exp_mem[2*w % 256] = (2*w < 256) ? col(8, 2*w) : exp_mem[2*w % 256];
            if (2*w+1 < 256) exp_mem[2*w+1] = col(8, 2*w+1);
        end
        check(load_done, "R2 restart burst length", int'(load_done), 1);
        @(negedge clk);
        lookup(0, 1'b1, "R2 entry 0 after restart");
        lookup(5, 1'b1, "R2 entry 5 after restart");
    endtask

    task automatic t_collision();
        do_load(3'd3, 9, 4'h3, 10);
        lookup(20, 1'b1, "R10 new colour after write");
        lookup(21, 1'b1, "R4 odd entry");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load8();
        t_idle_words();
        t_short_modes();
        t_mismatch();
        t_restart();
        t_collision();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R3 watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule